// File: doc/BRIEF.md
# Receive Character Queue with Error Status Modes

This block sits between a serial receiver and the bus side of a UART channel. The receiver hands it assembled characters. Each character comes with three error bits: parity error, framing error and break. The receiver also sends a one-cycle pulse whenever it sees the start bit of a new frame. The queue keeps up to eight characters with their error bits and shows the oldest one to the reader. It reports a fill level that saturates at seven, alongside a separate full flag.

When the queue is full, one more character waits in a single holding register until space opens. A start bit that arrives while that register is still occupied means the waiting character is lost. This is reported as a sticky overrun.

The error status can be read in two ways. It can show the bits of the oldest stored character alone. It can also show the OR of the bits of every character that has reached the head of the queue since the last clear. An idle timer counts bit-time ticks and raises an interrupt when characters have sat unread for 64 ticks.

Top module: `rxq_status_fifo`

## Requirements
- R1: The queue stores up to 8 characters, each an 8-bit byte with its own parity, framing and break bits. A pop returns them in arrival order with the bits that arrived with each one.
- R2: `fill_cnt` equals the number of stored characters for 0 to 7. With 8 stored, it reads 7 and `full` is 1.
- R3: `ready` is 1 whenever at least one character is stored, and 0 when none is.
- R4: With `err_mode`=0, `rd_stat` shows the head entry's bits as {break, framing, parity} in bits [2:0]. It is 0 when the queue is empty.
- R5: With `err_mode`=1, each bit of `rd_stat` is the OR of that bit over every entry that has been at the head since the last `err_clr`, including the present head.
- R6: Only `rd_pop` removes an entry, and it takes the byte and its bits together. A pop on an empty queue changes nothing. Holding the outputs for any number of cycles changes nothing.
- R7: A character that arrives while the queue holds 8 is kept in a holding register. It enters the queue in the cycle a pop frees a slot.
- R8: A `start_bit` pulse while the holding register is occupied and no slot frees discards the held character. It leaves the 8 stored entries untouched and sets `overrun` on the next clock.
- R9: With `wdog_en`=1, the timer restarts on every push into the queue and every pop. After 64 `bit_tick` pulses without a restart, `wdog_irq` goes to 1 if the queue is non-empty.
- R10: `overrun` stays 1 until `err_clr`. `err_clr` also empties the block-mode accumulators.
- R11: `wdog_irq` never fires with the queue empty. It is cleared by the next push or pop, and it is held at 0 while `wdog_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe: a character is delivered |
| wr_data | input | 8 | Received byte |
| wr_perr | input | 1 | Parity error of the delivered character |
| wr_ferr | input | 1 | Framing error of the delivered character |
| wr_brk | input | 1 | Break flag of the delivered character |
| start_bit | input | 1 | Pulse when the receiver detects a new start bit |
| rd_pop | input | 1 | Data read: removes the head entry |
| bit_tick | input | 1 | One pulse per bit time |
| err_mode | input | 1 | 0 = per-character status, 1 = accumulated status |
| err_clr | input | 1 | Clears overrun and the accumulators |
| wdog_en | input | 1 | Enables the idle timer |
| rd_data | output | 8 | Head byte (0 when empty) |
| rd_stat | output | 3 | {break, framing, parity} per the selected mode |
| fill_cnt | output | 3 | Saturating fill level |
| ready | output | 1 | At least one entry stored |
| full | output | 1 | Eight entries stored |
| overrun | output | 1 | Sticky overrun flag |
| wdog_irq | output | 1 | Idle timeout interrupt |

## Verification
The checker watches these properties on every cycle:
- the fill encoding at saturation;
- that `ready` follows the count;
- that an empty queue in character mode reports zero status;
- that accumulated bits never drop without a clear;
- that the overrun flag is sticky;
- that the timeout interrupt never coexists with an empty queue or a disabled timer.

Only the bench scenarios can show four things:
- the ordering and pairing of bytes with their own error bits;
- which character survives an overrun (the held one is lost, the later one kept);
- the exact 64-tick boundary of the timer;
- the accumulation history across several pops.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 3;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  rxq_entry_t push_ent,
  input  logic       pop,
  output rxq_entry_t head_ent,
  output logic [CW-1:0] count
);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

  rxq_entry_t mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_d;

  // storage: one enabled register per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wptr_q == AW'(i))) mem[i] <= push_ent;
    end
  end

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = count;
    if (push) wptr_d = (wptr_q == LAST_P) ? '0 : wptr_q + 1'b1;
    if (pop)  rptr_d = (rptr_q == LAST_P) ? '0 : rptr_q + 1'b1;
    if (push && !pop)      cnt_d = count + 1'b1;
    else if (pop && !push) cnt_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      count  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      count  <= cnt_d;
    end
  end

  assign head_ent = mem[rptr_q];
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  rxq_entry_t wr_ent,
  input  logic       start_bit,
  input  logic       space,
  input  logic       err_clr,
  output logic       push,
  output rxq_entry_t push_ent,
  output logic       overrun
);
  logic       hold_vld_q, hold_vld_d;
  rxq_entry_t hold_ent_q, hold_ent_d;
  logic       hold_load;
  logic       ovr_set, ovr_d;

  always_comb begin
    hold_vld_d = hold_vld_q;
    hold_ent_d = hold_ent_q;
    hold_load  = 1'b0;
    ovr_set    = 1'b0;
    if (hold_vld_q) begin
      push     = space;
      push_ent = hold_ent_q;
      if (space) begin
        hold_vld_d = wr_valid;
        hold_load  = wr_valid;
      end else if (wr_valid) begin
        hold_load  = 1'b1;
        ovr_set    = 1'b1;
      end else if (start_bit) begin
        hold_vld_d = 1'b0;
        ovr_set    = 1'b1;
      end
    end else begin
      push     = wr_valid && space;
      push_ent = wr_ent;
      if (wr_valid && !space) begin
        hold_vld_d = 1'b1;
        hold_load  = 1'b1;
      end
    end
    if (hold_load) hold_ent_d = wr_ent;
    if (ovr_set)      ovr_d = 1'b1;
    else if (err_clr) ovr_d = 1'b0;
    else              ovr_d = overrun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      hold_vld_q <= hold_vld_d;
      overrun    <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_load) hold_ent_q <= hold_ent_d;
  end
endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_mode,
  input  logic              err_clr,
  input  logic              head_vld,
  input  logic [STAT_W-1:0] head_stat,
  output logic [STAT_W-1:0] stat
);
  logic [STAT_W-1:0] acc_q, acc_d, cur;

  always_comb begin
    cur   = head_vld ? head_stat : '0;
    acc_d = err_clr ? '0 : (acc_q | cur);
    stat  = err_mode ? (acc_q | cur) : cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/rxq_wdog.sv
module rxq_wdog #(
  parameter int TICKS = 64,
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic restart,
  input  logic nonempty,
  output logic irq
);
  localparam logic [TW-1:0] LAST_T = TW'(TICKS - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          expire, irq_d;

  always_comb begin
    expire = en && !restart && tick && (cnt_q == LAST_T);
    if (!en || restart)  cnt_d = '0;
    else if (tick)       cnt_d = (cnt_q == LAST_T) ? '0 : cnt_q + 1'b1;
    else                 cnt_d = cnt_q;
    if (!en || restart)          irq_d = 1'b0;
    else if (expire && nonempty) irq_d = 1'b1;
    else                         irq_d = irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq   <= irq_d;
    end
  end
endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WDOG_TICKS = 64,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int FW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_perr,
  input  logic              wr_ferr,
  input  logic              wr_brk,
  input  logic              start_bit,
  input  logic              rd_pop,
  input  logic              bit_tick,
  input  logic              err_mode,
  input  logic              err_clr,
  input  logic              wdog_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] rd_stat,
  output logic [FW-1:0]     fill_cnt,
  output logic              ready,
  output logic              full,
  output logic              overrun,
  output logic              wdog_irq
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          rst_meta, rst_sync;
  rxq_entry_t    wr_ent, push_ent, head_ent;
  logic          push, pop_ok, space;
  logic [CW-1:0] count;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    wr_ent.brk  = wr_brk;
    wr_ent.ferr = wr_ferr;
    wr_ent.perr = wr_perr;
    wr_ent.data = wr_data;
    ready  = (count != '0);
    full   = (count == DEPTH_C);
    pop_ok = rd_pop && ready;
    space  = !full || pop_ok;
    fill_cnt = full ? '1 : count[FW-1:0];
    rd_data  = ready ? head_ent.data : '0;
  end

  rxq_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_sync),
    .wr_valid (wr_valid),
    .wr_ent   (wr_ent),
    .start_bit(start_bit),
    .space    (space),
    .err_clr  (err_clr),
    .push     (push),
    .push_ent (push_ent),
    .overrun  (overrun)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync),
    .push    (push),
    .push_ent(push_ent),
    .pop     (pop_ok),
    .head_ent(head_ent),
    .count   (count)
  );

  rxq_errstat u_stat (
    .clk      (clk),
    .rst_n    (rst_sync),
    .err_mode (err_mode),
    .err_clr  (err_clr),
    .head_vld (ready),
    .head_stat({head_ent.brk, head_ent.ferr, head_ent.perr}),
    .stat     (rd_stat)
  );

  rxq_wdog #(.TICKS(WDOG_TICKS)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_sync),
    .en      (wdog_en),
    .tick    (bit_tick),
    .restart (push || pop_ok),
    .nonempty(ready),
    .irq     (wdog_irq)
  );
endmodule

// File: rtl/rxq_status_fifo_chk.sv
module rxq_status_fifo_chk #(
  parameter int FW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          start_bit,
  input logic          rd_pop,
  input logic          err_mode,
  input logic          err_clr,
  input logic          wdog_en,
  input logic [2:0]    rd_stat,
  input logic [FW-1:0] fill_cnt,
  input logic          ready,
  input logic          full,
  input logic          overrun,
  input logic          wdog_irq
);
  a_r2_full_reads_max: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (fill_cnt == '1));

  a_r3_ready_with_count: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt != '0) |-> ready);

  a_r4_empty_zero_stat: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !err_mode) |-> (rd_stat == 3'b000));

  a_r5_block_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mode && !err_clr) |=> (!err_mode || ((rd_stat & $past(rd_stat)) == $past(rd_stat))));

  a_r6_no_loss_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pop && !full) |=> (full || (fill_cnt >= $past(fill_cnt))));

  a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(start_bit || wr_valid));

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr) |=> overrun);

  a_r11_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_irq |-> ready);

  a_r11_irq_off_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !wdog_en |=> !wdog_irq);
endmodule

bind rxq_status_fifo rxq_status_fifo_chk #(.FW(FW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .start_bit(start_bit),
  .rd_pop   (rd_pop),
  .err_mode (err_mode),
  .err_clr  (err_clr),
  .wdog_en  (wdog_en),
  .rd_stat  (rd_stat),
  .fill_cnt (fill_cnt),
  .ready    (ready),
  .full     (full),
  .overrun  (overrun),
  .wdog_irq (wdog_irq)
);

// File: tb/tb_rxq_status_fifo.sv
module tb_rxq_status_fifo;
  logic       clk, rst_n;
  logic       wr_valid, wr_perr, wr_ferr, wr_brk, start_bit, rd_pop, bit_tick;
  logic       err_mode, err_clr, wdog_en;
  logic [7:0] wr_data, rd_data;
  logic [2:0] rd_stat, fill_cnt;
  logic       ready, full, overrun, wdog_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [10:0] exp_q[$];
  logic [10:0] hold_e;
  bit          hold_v = 0;

  rxq_status_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk), .start_bit(start_bit),
    .rd_pop(rd_pop), .bit_tick(bit_tick), .err_mode(err_mode), .err_clr(err_clr),
    .wdog_en(wdog_en), .rd_data(rd_data), .rd_stat(rd_stat), .fill_cnt(fill_cnt),
    .ready(ready), .full(full), .overrun(overrun), .wdog_irq(wdog_irq)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: delivers one character and updates the model
  task automatic push_char(input logic [10:0] e);
    @(negedge clk);
    wr_valid = 1; wr_data = e[7:0];
    wr_perr = e[8]; wr_ferr = e[9]; wr_brk = e[10];
    if (exp_q.size() < 8 && !hold_v) exp_q.push_back(e);
    else begin hold_v = 1; hold_e = e; end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic pop_one();
    @(negedge clk); rd_pop = 1;
    @(negedge clk); rd_pop = 0;
  endtask

  task automatic start_pulse();
    @(negedge clk); start_bit = 1;
    if (hold_v) hold_v = 0;
    @(negedge clk); start_bit = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
  endtask

  task automatic clr_pulse();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  // monitor: compares every accepted pop with the scoreboard head (R1, R4)
  always @(posedge clk) begin
    if (rst_n && rd_pop && ready) begin
      logic [10:0] e;
      if (exp_q.size() == 0) begin
        chk(0, "R1 pop with empty model", rd_data, 0);
      end else begin
        e = exp_q.pop_front();
        chk(rd_data == e[7:0], "R1 data order", rd_data, e[7:0]);
        if (!err_mode) chk(rd_stat == e[10:8], "R4 per-char status", rd_stat, e[10:8]);
        if (hold_v) begin
          exp_q.push_back(hold_e);
          hold_v = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_valid = 0; wr_data = 0; wr_perr = 0; wr_ferr = 0; wr_brk = 0;
    start_bit = 0; rd_pop = 0; bit_tick = 0; err_mode = 0; err_clr = 0; wdog_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // reset state
    chk(!ready && !full && fill_cnt == 0, "R3 reset empty", {ready, full, fill_cnt}, 0);
    chk(!overrun && !wdog_irq, "R10 reset flags", {overrun, wdog_irq}, 0);

    // R6: pop on empty ignored
    pop_one();
    chk(fill_cnt == 0 && !ready, "R6 empty pop ignored", fill_cnt, 0);

    // R1/R4: three characters with distinct status
    push_char({3'b001, 8'hA5});
    push_char({3'b100, 8'h00});
    push_char({3'b010, 8'h3C});
    chk(fill_cnt == 3 && ready, "R2 count three", fill_cnt, 3);
    chk(rd_stat == 3'b001, "R4 head status", rd_stat, 1);
    repeat (5) @(negedge clk);
    chk(fill_cnt == 3 && rd_data == 8'hA5, "R6 no pop while idle", fill_cnt, 3);
    pop_one(); pop_one(); pop_one();
    chk(!ready && rd_stat == 0, "R3 drained", {ready, rd_stat}, 0);

    // R2/R7: fill to eight, hold a ninth
    for (int i = 0; i < 8; i++) push_char({3'(i), 8'(8'h10 + i)});
    chk(full && fill_cnt == 7, "R2 full saturates", {full, fill_cnt}, 4'hF);
    push_char({3'b000, 8'h99});
    chk(full && fill_cnt == 7 && !overrun, "R7 ninth held", {full, overrun}, 2);
    pop_one();
    chk(full && fill_cnt == 7, "R7 held moved in", {full, fill_cnt}, 4'hF);
    for (int i = 0; i < 8; i++) pop_one();
    chk(!ready, "R7 all drained", ready, 0);

    // R8/R10: overrun discards the held character
    for (int i = 0; i < 8; i++) push_char({3'b000, 8'(8'h40 + i)});
    push_char({3'b001, 8'hEE});
    start_pulse();
    chk(overrun, "R8 overrun set", overrun, 1);
    chk(full && rd_data == 8'h40, "R8 queue untouched", rd_data, 8'h40);
    push_char({3'b000, 8'h77});
    for (int i = 0; i < 9; i++) pop_one();
    chk(!ready, "R8 drained", ready, 0);
    chk(overrun, "R10 overrun sticky", overrun, 1);
    clr_pulse();
    chk(!overrun, "R10 overrun cleared", overrun, 0);

    // R5: block mode accumulation
    err_mode = 1;
    push_char({3'b001, 8'h01});
    push_char({3'b000, 8'h02});
    push_char({3'b010, 8'h03});
    chk(rd_stat == 3'b001, "R5 first top", rd_stat, 1);
    pop_one();
    chk(rd_stat == 3'b001, "R5 keeps parity", rd_stat, 1);
    pop_one();
    chk(rd_stat == 3'b011, "R5 or framing", rd_stat, 3);
    clr_pulse();
    chk(rd_stat == 3'b010, "R10 clear leaves top", rd_stat, 2);
    pop_one();
    chk(rd_stat == 3'b010 && !ready, "R5 history after empty", rd_stat, 2);
    clr_pulse();
    chk(rd_stat == 0, "R10 accumulators cleared", rd_stat, 0);
    err_mode = 0;

    // R9/R11: idle timer
    @(negedge clk); wdog_en = 1;
    ticks(64);
    chk(!wdog_irq, "R11 no irq when empty", wdog_irq, 0);
    push_char({3'b000, 8'h55});
    ticks(63);
    chk(!wdog_irq, "R9 not before 64", wdog_irq, 0);
    ticks(1);
    chk(wdog_irq, "R9 fires at 64", wdog_irq, 1);
    push_char({3'b000, 8'h56});
    chk(!wdog_irq, "R11 push clears", wdog_irq, 0);
    ticks(64);
    chk(wdog_irq, "R9 fires again", wdog_irq, 1);
    pop_one();
    chk(!wdog_irq, "R11 read clears", wdog_irq, 0);
    ticks(64);
    @(negedge clk); wdog_en = 0;
    @(negedge clk);
    chk(!wdog_irq, "R11 off when disabled", wdog_irq, 0);
    pop_one();
    chk(exp_q.size() == 0 && !ready, "R1 scoreboard empty", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule